// File: doc/BRIEF.md
# Transmit Descriptor Status Sequencer

This block sits beside the DMA engine of an Ethernet transmitter and decides, per frame, when the transmit descriptor gets its status write-back and when the status flags are raised. It reads each fetched descriptor's valid bit and its two-bit segment code. A valid descriptor starts a frame. While that frame is in progress the block waits for one of three outcomes: the frame completes, the transmit path aborts it, or the transmit FIFO runs dry. Each outcome leads to a write-back request that stays high until the memory side acknowledges it.

The flags follow a fixed order around the write-back. An abort raises its flag only once the write-back is acknowledged. An underflow raises one flag together with the write-back request and a second flag once the write-back is acknowledged. An abort also cancels a DMA fetch that is still running for the frame. When an invalid descriptor follows a descriptor that opened or continued a multi-segment frame, the block flags an empty descriptor ring. It then halts until software resets it.

All flags are sticky and are cleared by writing ones. One interrupt line reports any flag that its mask enables.

Top module: `txdesc_seq`

## Requirements
- R1: After reset, or in the cycle after `swReset` is sampled high, `flags` is 0, `wbReq`, `dmaAbort` and `halted` are low, and the stored previous segment code is 2'b11.
- R2: In the frame-active state, a sampled `frameDone` raises `wbReq` in the next cycle. `wbReq` stays high until `wbAck` is sampled, and it drops in the cycle after that.
- R3: A `txAbort` sampled while a frame is active raises `wbReq` in the next cycle. Flag bit 0 (abort) is set only by the edge that samples `wbAck` during that write-back.
- R4: A `txAbort` sampled while a frame is active drives `dmaAbort` high for exactly one cycle if `dmaDone` has not been sampled since the descriptor was accepted, including the abort edge itself. Otherwise `dmaAbort` stays low.
- R5: A `txUnderflow` sampled while a frame is active sets flag bit 1 (underflow) at the same edge that raises `wbReq`. Flag bit 2 (underrun) is set by the edge that samples `wbAck`.
- R6: Segment codes are 2'b10 first, 2'b00 middle, 2'b01 last and 2'b11 single. The empty condition arises when `descRd` is sampled in idle with `descActive` low and the previous accepted segment code is 2'b00 or 2'b10. It sets flag bit 3 (empty) and raises `halted`.
- R7: An invalid descriptor read when the previous code is 2'b01 or 2'b11 sets no flag. The block stays idle.
- R8: While `halted` is high, descriptor reads and frame events are ignored, with no `wbReq` and no flag change other than clears. Only `swReset` leaves this state.
- R9: After an abort or underflow write-back, the next valid descriptor is accepted and processed like any other.
- R10: Each flag bit is cleared by a 1 on the matching `flagClr` bit. A set in the same cycle takes priority over the clear.
- R11: `irq` is high exactly when some bit is set in both `flags` and `intMask`. It follows `intMask` in the same cycle.
- R12: When several frame events are sampled together, `txAbort` wins over `txUnderflow`, which wins over `frameDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swReset | input | 1 | Software reset; clears all state |
| descRd | input | 1 | Strobe: a descriptor has been fetched |
| descActive | input | 1 | Valid bit of the fetched descriptor |
| descPos | input | 2 | Segment code of the fetched descriptor |
| dmaDone | input | 1 | DMA fetch of the current frame finished |
| frameDone | input | 1 | Frame sent without error |
| txAbort | input | 1 | Transmit error abort |
| txUnderflow | input | 1 | Transmit FIFO ran empty mid-frame |
| wbAck | input | 1 | Descriptor write-back acknowledged |
| flagClr | input | 4 | Write-one-to-clear flag bits |
| intMask | input | 4 | Interrupt enable per flag |
| wbReq | output | 1 | Descriptor write-back request |
| dmaAbort | output | 1 | One-cycle DMA abort pulse |
| flags | output | 4 | Sticky flags: 0 abort, 1 underflow, 2 underrun, 3 empty |
| irq | output | 1 | Interrupt request |
| halted | output | 1 | Processing stopped on empty ring |

## Verification
Every registered result appears one edge after the input that causes it. `wbReq`, `dmaAbort`, the underflow flag, the empty flag and `halted` change at the edge that samples the event. The abort and underrun flags change at the edge that samples `wbAck`. `irq` is combinational from `intMask`, so it must react in the same cycle. The bench applies inputs just after a rising edge, lets a behavioural model advance on the next rising edge, and compares every output at the falling edge. Directed checks are read just after the edge that consumed the stimulus, where the one-cycle latency puts the new value.

// File: rtl/txds_pkg.sv
package txds_pkg;
  localparam int POS_W  = 2;
  localparam int NFLAG  = 4;
  localparam int F_ABT  = 0;
  localparam int F_UF   = 1;
  localparam int F_UR   = 2;
  localparam int F_EMPTY = 3;
  localparam logic [POS_W-1:0] POS_MID    = 2'b00;
  localparam logic [POS_W-1:0] POS_FIRST  = 2'b10;
  localparam logic [POS_W-1:0] POS_SINGLE = 2'b11;

  typedef enum logic [2:0] {
    S_IDLE, S_ACTIVE, S_WB_OK, S_WB_ABT, S_WB_UF, S_HALT
  } seq_state_t;

  typedef struct packed {
    logic clearAll;
    logic accept;
    logic abortDma;
    logic setAbt;
    logic setUf;
    logic setUr;
    logic setEmpty;
  } seq_strb_t;
endpackage

// File: rtl/txds_ctrl.sv
module txds_ctrl
  import txds_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             swReset,
  input  logic             descRd,
  input  logic             descActive,
  input  logic [POS_W-1:0] prevPos,
  input  logic             frameDone,
  input  logic             txAbort,
  input  logic             txUnderflow,
  input  logic             wbAck,
  output seq_strb_t        strb,
  output logic             wbReq,
  output logic             halted
);
  seq_state_t state, stateNxt;
  logic prevOpen;

  assign prevOpen = (prevPos == POS_MID) || (prevPos == POS_FIRST);

  always_comb begin
    stateNxt = state;
    strb     = '0;
    strb.clearAll = swReset;
    if (!swReset) begin
      unique case (state)
        S_IDLE: if (descRd) begin
          if (descActive) begin
            strb.accept = 1'b1;
            stateNxt    = S_ACTIVE;
          end else if (prevOpen) begin
            strb.setEmpty = 1'b1;
            stateNxt      = S_HALT;
          end
        end
        S_ACTIVE: begin
          if (txAbort) begin
            strb.abortDma = 1'b1;
            stateNxt      = S_WB_ABT;
          end else if (txUnderflow) begin
            strb.setUf = 1'b1;
            stateNxt   = S_WB_UF;
          end else if (frameDone) begin
            stateNxt = S_WB_OK;
          end
        end
        S_WB_OK:  if (wbAck) stateNxt = S_IDLE;
        S_WB_ABT: if (wbAck) begin
          strb.setAbt = 1'b1;
          stateNxt    = S_IDLE;
        end
        S_WB_UF:  if (wbAck) begin
          strb.setUr = 1'b1;
          stateNxt   = S_IDLE;
        end
        S_HALT:   stateNxt = S_HALT;
        default:  stateNxt = S_IDLE;
      endcase
    end else begin
      stateNxt = S_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  assign wbReq  = (state == S_WB_OK) || (state == S_WB_ABT) || (state == S_WB_UF);
  assign halted = (state == S_HALT);
endmodule

// File: rtl/txds_dpath.sv
module txds_dpath
  import txds_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  seq_strb_t        strb,
  input  logic [POS_W-1:0] descPos,
  input  logic             dmaDone,
  input  logic [NFLAG-1:0] flagClr,
  input  logic [NFLAG-1:0] intMask,
  output logic [POS_W-1:0] prevPos,
  output logic [NFLAG-1:0] flags,
  output logic             dmaAbort,
  output logic             irq
);
  logic [NFLAG-1:0] setVec;
  logic             dmaPending;

  always_comb begin
    setVec          = '0;
    setVec[F_ABT]   = strb.setAbt;
    setVec[F_UF]    = strb.setUf;
    setVec[F_UR]    = strb.setUr;
    setVec[F_EMPTY] = strb.setEmpty;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN || strb.clearAll) flags[i] <= 1'b0;
      else if (setVec[i])         flags[i] <= 1'b1;
      else if (flagClr[i])        flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clearAll) begin
      prevPos    <= POS_SINGLE;
      dmaPending <= 1'b0;
      dmaAbort   <= 1'b0;
    end else begin
      dmaAbort <= strb.abortDma && dmaPending && !dmaDone;
      if (strb.accept) begin
        prevPos    <= descPos;
        dmaPending <= 1'b1;
      end else if (dmaDone || strb.abortDma) begin
        dmaPending <= 1'b0;
      end
    end
  end

  assign irq = |(flags & intMask);
endmodule

// File: rtl/txdesc_seq.sv
module txdesc_seq
  import txds_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             swReset,
  input  logic             descRd,
  input  logic             descActive,
  input  logic [POS_W-1:0] descPos,
  input  logic             dmaDone,
  input  logic             frameDone,
  input  logic             txAbort,
  input  logic             txUnderflow,
  input  logic             wbAck,
  input  logic [NFLAG-1:0] flagClr,
  input  logic [NFLAG-1:0] intMask,
  output logic             wbReq,
  output logic             dmaAbort,
  output logic [NFLAG-1:0] flags,
  output logic             irq,
  output logic             halted
);
  seq_strb_t        strb;
  logic [POS_W-1:0] prevPos;

  txds_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .swReset(swReset), .descRd(descRd),
    .descActive(descActive), .prevPos(prevPos), .frameDone(frameDone),
    .txAbort(txAbort), .txUnderflow(txUnderflow), .wbAck(wbAck),
    .strb(strb), .wbReq(wbReq), .halted(halted)
  );

  txds_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .descPos(descPos),
    .dmaDone(dmaDone), .flagClr(flagClr), .intMask(intMask),
    .prevPos(prevPos), .flags(flags), .dmaAbort(dmaAbort), .irq(irq)
  );
endmodule

// File: rtl/txdesc_seq_chk.sv
module txdesc_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       swReset,
  input logic       wbAck,
  input logic       wbReq,
  input logic       dmaAbort,
  input logic [3:0] flags,
  input logic       halted
);
  // R2
  wbreq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbReq && !wbAck && !swReset |=> wbReq);
  // R3
  abort_after_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[0]) |-> $past(wbReq && wbAck));
  // R5
  underrun_after_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[2]) |-> $past(wbReq && wbAck));
  // R5
  underflow_with_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[1]) |-> wbReq);
  // R4
  dma_abort_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaAbort |=> !dmaAbort);
  // R6
  halt_flags_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halted) |-> flags[3]);
  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted && !swReset |=> halted && !wbReq);
endmodule

bind txdesc_seq txdesc_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .swReset(swReset), .wbAck(wbAck), .wbReq(wbReq),
  .dmaAbort(dmaAbort), .flags(flags), .halted(halted)
);

// File: tb/tb_txdesc_seq.sv
module tb_txdesc_seq;
  logic clk = 1'b0, rstN = 1'b0;
  logic swReset = 0, descRd = 0, descActive = 0, dmaDone = 0;
  logic frameDone = 0, txAbort = 0, txUnderflow = 0, wbAck = 0;
  logic [1:0] descPos = 0;
  logic [3:0] flagClr = 0, intMask = 4'hF;
  logic wbReq, dmaAbort, irq, halted;
  logic [3:0] flags;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  txdesc_seq dut (.*);

  // behavioural reference: 0 idle,1 active,2 wb ok,3 wb abort,4 wb underflow,5 halt
  int mSt = 0;
  int mPrev = 3;
  bit mPend = 0, mDab = 0;
  logic [3:0] mFl = 0;

  always @(posedge clk) begin
    if (!rstN || swReset) begin
      mSt = 0; mPrev = 3; mPend = 0; mDab = 0; mFl = 0;
    end else begin
      logic [3:0] nf;
      bit oldPend;
      nf = mFl & ~flagClr;
      oldPend = mPend;
      mDab = 0;
      if (dmaDone) mPend = 0;
      case (mSt)
        0: if (descRd) begin
             if (descActive) begin mPrev = descPos; mPend = 1; mSt = 1; end
             else if (mPrev == 0 || mPrev == 2) begin nf[3] = 1; mSt = 5; end
           end
        1: if (txAbort) begin mDab = oldPend && !dmaDone; mPend = 0; mSt = 3; end
           else if (txUnderflow) begin nf[1] = 1; mSt = 4; end
           else if (frameDone) mSt = 2;
        2: if (wbAck) mSt = 0;
        3: if (wbAck) begin nf[0] = 1; mSt = 0; end
        4: if (wbAck) begin nf[2] = 1; mSt = 0; end
        default: ;
      endcase
      mFl = nf;
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rstN) begin
    cmp("R2 model wbReq", wbReq, (mSt >= 2 && mSt <= 4));
    cmp("R4 model dmaAbort", dmaAbort, mDab);
    cmp("R5 model flags", flags, mFl);
    cmp("R11 model irq", irq, |(mFl & intMask));
    cmp("R8 model halted", halted, mSt == 5);
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic desc(input bit act, input logic [1:0] pos);
    descRd = 1; descActive = act; descPos = pos; cyc(1);
    descRd = 0; descActive = 0;
  endtask

  task automatic ack();
    wbAck = 1; cyc(1); wbAck = 0;
  endtask

  initial begin
    cyc(3);
    rstN = 1;
    cyc(1);
    // R1 reset state
    cmp("R1 flags", flags, 0); cmp("R1 wbReq", wbReq, 0);
    cmp("R1 halted", halted, 0); cmp("R1 irq", irq, 0);

    // R2 normal frame, ack delayed
    desc(1, 2'b11);
    frameDone = 1; cyc(1); frameDone = 0;
    cmp("R2 wbReq up", wbReq, 1);
    cyc(3);
    cmp("R2 wbReq held", wbReq, 1); cmp("R2 no flags", flags, 0);
    ack();
    cmp("R2 wbReq dropped", wbReq, 0);

    // R3 R4 abort while DMA busy
    desc(1, 2'b11);
    txAbort = 1; cyc(1); txAbort = 0;
    cmp("R4 dmaAbort pulse", dmaAbort, 1);
    cmp("R3 wbReq", wbReq, 1); cmp("R3 flag not yet", flags[0], 0);
    cyc(1);
    cmp("R4 pulse ends", dmaAbort, 0); cmp("R3 flag still clear", flags[0], 0);
    ack();
    cmp("R3 abort flag", flags, 4'b0001); cmp("R11 irq", irq, 1);

    // R10 clear
    flagClr = 4'hF; cyc(1); flagClr = 0;
    cmp("R10 cleared", flags, 0);

    // R4 abort after DMA finished
    desc(1, 2'b11);
    dmaDone = 1; cyc(1); dmaDone = 0;
    txAbort = 1; cyc(1); txAbort = 0;
    cmp("R4 no dmaAbort", dmaAbort, 0);
    ack();

    // R5 underflow ordering
    flagClr = 4'hF; cyc(1); flagClr = 0;
    desc(1, 2'b10);
    txUnderflow = 1; cyc(1); txUnderflow = 0;
    cmp("R5 underflow first", flags, 4'b0010); cmp("R5 wbReq", wbReq, 1);
    cyc(1);
    ack();
    cmp("R5 underrun after wb", flags, 4'b0110);

    // R9 next descriptor normal
    desc(1, 2'b01);
    frameDone = 1; cyc(1); frameDone = 0;
    cmp("R9 wbReq", wbReq, 1);
    ack();
    cmp("R9 no new flags", flags, 4'b0110);

    // R11 masking
    intMask = 4'b1001; #1;
    cmp("R11 masked", irq, 0);
    intMask = 4'b0100; #1;
    cmp("R11 enabled", irq, 1);
    intMask = 4'hF;

    // R10 set beats clear
    flagClr = 4'hF; cyc(1);
    desc(1, 2'b11);
    txUnderflow = 1; cyc(1); txUnderflow = 0; flagClr = 0;
    cmp("R10 set wins", flags[1], 1);
    ack();
    flagClr = 4'hF; cyc(1); flagClr = 0;

    // R12 priority
    desc(1, 2'b11);
    txAbort = 1; txUnderflow = 1; frameDone = 1; cyc(1);
    txAbort = 0; txUnderflow = 0; frameDone = 0;
    cmp("R12 underflow suppressed", flags, 0);
    ack();
    cmp("R12 abort chosen", flags, 4'b0001);
    flagClr = 4'hF; cyc(1); flagClr = 0;

    // R7 invalid after single/last
    desc(0, 2'b00);
    cmp("R7 not halted", halted, 0); cmp("R7 no flag", flags, 0);

    // R6 empty after middle segment
    desc(1, 2'b00);
    frameDone = 1; cyc(1); frameDone = 0; ack();
    desc(0, 2'b00);
    cmp("R6 halted", halted, 1); cmp("R6 empty flag", flags, 4'b1000);

    // R8 ignored while halted
    desc(1, 2'b11);
    frameDone = 1; cyc(1); frameDone = 0;
    cmp("R8 still halted", halted, 1); cmp("R8 no wbReq", wbReq, 0);
    swReset = 1; cyc(1); swReset = 0;
    cmp("R8 released", halted, 0); cmp("R1 sw reset flags", flags, 0);

    // R6 empty after first segment
    desc(1, 2'b10);
    frameDone = 1; cyc(1); frameDone = 0; ack();
    desc(0, 2'b11);
    cmp("R6 first-seg empty", halted, 1);
    cyc(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule